// File: doc/BRIEF.md
# Trap Entry State Unit

This unit performs the architectural bookkeeping a processor core needs when it takes a trap and when it returns from one. On a trap request it receives the trap type and the current values of the program counters, condition codes, address space identifier, processor state, hypervisor state, window pointer, save-window count and global level. In the next cycle it raises the trap level and pushes a snapshot of that state onto a small per-level trap stack. It also presents the updated processor state, hypervisor state, global level, window pointer and program counters.

The saved state word packs the global level, condition codes, address space identifier, processor state and window pointer at fixed bit positions, so that a return can unpack them again. The window pointer moves by an amount chosen by the trap-type range and wraps modulo the number of windows. Spill and fill traps redirect the program counters to fixed handler bases. A return request pops the entry at the current level, restores the state from it and lowers the level. Trying to trap at the deepest level raises a sticky error flag instead.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, tl is 0, error_state, trap_done and ret_done are 0, and every nxt_* and stk_* output is 0.
- R2: A trap_req sampled while tl < MAX_TL (6) raises tl by one and pulses trap_done for exactly one cycle after that edge. The stack entry at the new level (seen on stk_*) holds stk_tpc = cur_pc, stk_tnpc = cur_npc, stk_tt = trap_type and stk_htstate = cur_hpstate.
- R3: The saved state word stk_tstate holds cur_gl in bits 42:40, cur_ccr in 39:32, cur_asi in 31:24, cur_pstate in 20:8 and the zero-extended cur_cwp in 4:0. All other bits are zero.
- R4: On trap entry nxt_pstate equals cur_pstate with bit 4 set and bits 3 and 1 cleared. With hyp_mode = 0, bit 2 is set and bit 9 takes bit 8. With hyp_mode = 1, bits 2 and 9 are cleared.
- R5: On trap entry with hyp_mode = 1, nxt_hpstate equals cur_hpstate with bits 5 and 10 cleared and bit 2 set. With hyp_mode = 0, nxt_hpstate equals cur_hpstate.
- R6: On trap entry nxt_gl is cur_gl + 1, limited to MAX_PGL (2) when hyp_mode = 0 and to MAX_GL (3) when hyp_mode = 1.
- R7: On trap entry the window pointer moves by trap type. Type 9'h024 adds 1. Types 9'h080 to 9'h0BF (spill) add cur_cansave + 2. Types 9'h0C0 to 9'h0FF (fill) subtract 1. Every other type, including 9'h029, leaves it unchanged.
- R8: The adjusted window pointer wraps modulo NWIN (8): 7 + 1 gives 0, 0 - 1 gives 7, and a spill sum of 8 or more wraps.
- R9: A spill trap gives nxt_pc = SPILL_BASE, nxt_npc = SPILL_BASE + 4 and nxt_nnpc = SPILL_BASE + 8, and a fill trap does the same from FILL_BASE. Any other trap gives nxt_pc = cur_pc, nxt_npc = cur_npc and nxt_nnpc = cur_npc + 4.
- R10: A trap_req sampled while tl = MAX_TL sets error_state, which stays set until reset. It leaves tl and the stack unchanged and gives no trap_done.
- R11: A done_ret sampled with tl > 0 and no trap_req restores nxt_ccr, nxt_asi, nxt_pstate, nxt_cwp and nxt_gl from the fields of the entry at tl. It sets nxt_pc = saved TPC, nxt_npc = saved TNPC, nxt_nnpc = saved TNPC + 4 and nxt_hpstate = saved HTSTATE, lowers tl by one and pulses ret_done for one cycle. A done_ret at tl = 0 has no effect.
- R12: When trap_req and done_ret are sampled together, only the trap is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | 9 | Trap type code |
| hyp_mode | input | 1 | Deliver the trap at hypervisor level |
| done_ret | input | 1 | Return from the trap at the current level |
| cur_pc | input | 64 | Current program counter |
| cur_npc | input | 64 | Current next program counter |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_pstate | input | 13 | Current processor state |
| cur_hpstate | input | 12 | Current hypervisor state |
| cur_cwp | input | 3 | Current window pointer |
| cur_cansave | input | 3 | Current save-window count |
| cur_gl | input | 3 | Current global level |
| tl | output | 3 | Trap level |
| error_state | output | 1 | Sticky trap-stack overflow flag |
| trap_done | output | 1 | Trap entry completed |
| ret_done | output | 1 | Trap return completed |
| nxt_pc | output | 64 | Updated program counter |
| nxt_npc | output | 64 | Updated next program counter |
| nxt_nnpc | output | 64 | Updated next-next program counter |
| nxt_ccr | output | 8 | Updated condition codes |
| nxt_asi | output | 8 | Updated address space identifier |
| nxt_pstate | output | 13 | Updated processor state |
| nxt_hpstate | output | 12 | Updated hypervisor state |
| nxt_cwp | output | 3 | Updated window pointer |
| nxt_gl | output | 3 | Updated global level |
| stk_tstate | output | 64 | Saved state word at the current level |
| stk_tpc | output | 64 | Saved program counter at the current level |
| stk_tnpc | output | 64 | Saved next program counter at the current level |
| stk_tt | output | 9 | Saved trap type at the current level |
| stk_htstate | output | 12 | Saved hypervisor state at the current level |

## Verification
A wrong trap level or a write to the wrong stack slot shows up on the stk_* outputs in the very cycle trap_done rises, because they read the entry at the new level. A corrupted packing appears later, at the matching return, as a wrong restored field on the nxt_* outputs, and every return compares all restored fields. A window-pointer or global-level slip is visible in the cycle after the trap that caused it, and the type boundaries 9'h07F/9'h080, 9'h0BF/9'h0C0 and 9'h0FF/9'h100 are each driven once.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int NWIN = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int MAX_PGL = 2,
  parameter logic [63:0] SPILL_BASE = 64'h0000_0000_0001_0000,
  parameter logic [63:0] FILL_BASE = 64'h0000_0000_0002_0000,
  localparam int CW = $clog2(NWIN),
  localparam int TLW = $clog2(MAX_TL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trap_req,
  input  logic [8:0]     trap_type,
  input  logic           hyp_mode,
  input  logic           done_ret,
  input  logic [63:0]    cur_pc,
  input  logic [63:0]    cur_npc,
  input  logic [7:0]     cur_ccr,
  input  logic [7:0]     cur_asi,
  input  logic [12:0]    cur_pstate,
  input  logic [11:0]    cur_hpstate,
  input  logic [CW-1:0]  cur_cwp,
  input  logic [CW-1:0]  cur_cansave,
  input  logic [2:0]     cur_gl,
  output logic [TLW-1:0] tl,
  output logic           error_state,
  output logic           trap_done,
  output logic           ret_done,
  output logic [63:0]    nxt_pc,
  output logic [63:0]    nxt_npc,
  output logic [63:0]    nxt_nnpc,
  output logic [7:0]     nxt_ccr,
  output logic [7:0]     nxt_asi,
  output logic [12:0]    nxt_pstate,
  output logic [11:0]    nxt_hpstate,
  output logic [CW-1:0]  nxt_cwp,
  output logic [2:0]     nxt_gl,
  output logic [63:0]    stk_tstate,
  output logic [63:0]    stk_tpc,
  output logic [63:0]    stk_tnpc,
  output logic [8:0]     stk_tt,
  output logic [11:0]    stk_htstate
);

  localparam logic [CW+1:0] NW = (CW+2)'(NWIN);

  logic [63:0] tst_m [MAX_TL];
  logic [63:0] tpc_m [MAX_TL];
  logic [63:0] tnpc_m [MAX_TL];
  logic [8:0]  tt_m [MAX_TL];
  logic [11:0] hts_m [MAX_TL];

  logic at_top, at_bot, take, back, spill, fill, step1;
  logic [63:0] tst_new, base;
  logic [12:0] ps_new;
  logic [11:0] hps_new;
  logic [2:0]  gl_lim, gl_new;
  logic [CW+1:0] wsum;
  logic [CW-1:0] cwp_new;

  assign at_top = (tl == TLW'(MAX_TL));
  assign at_bot = (tl == '0);
  assign take   = trap_req && !at_top;
  assign back   = done_ret && !trap_req && !at_bot;
  assign spill  = (trap_type[8:6] == 3'b010);
  assign fill   = (trap_type[8:6] == 3'b011);
  assign step1  = (trap_type == 9'h024);
  assign base   = spill ? SPILL_BASE : FILL_BASE;

  assign tst_new = {21'b0, cur_gl, cur_ccr, cur_asi, 3'b0, cur_pstate, 3'b0, 5'(cur_cwp)};

  always_comb begin
    ps_new = cur_pstate;
    ps_new[4] = 1'b1;
    ps_new[3] = 1'b0;
    ps_new[1] = 1'b0;
    ps_new[2] = !hyp_mode;
    ps_new[9] = hyp_mode ? 1'b0 : cur_pstate[8];
    hps_new = cur_hpstate;
    if (hyp_mode) begin
      hps_new[5]  = 1'b0;
      hps_new[10] = 1'b0;
      hps_new[2]  = 1'b1;
    end
  end

  assign gl_lim = hyp_mode ? 3'(MAX_GL) : 3'(MAX_PGL);
  assign gl_new = (cur_gl >= gl_lim) ? gl_lim : cur_gl + 3'd1;

  always_comb begin
    wsum = {2'b0, cur_cwp};
    if (step1)
      wsum = {2'b0, cur_cwp} + (CW+2)'(1);
    else if (spill)
      wsum = {2'b0, cur_cwp} + {2'b0, cur_cansave} + (CW+2)'(2);
    else if (fill)
      wsum = (cur_cwp == '0) ? NW - (CW+2)'(1) : {2'b0, cur_cwp} - (CW+2)'(1);
    if (wsum >= NW) wsum = wsum - NW;
    if (wsum >= NW) wsum = wsum - NW;
    cwp_new = CW'(wsum);
  end

  always_comb begin
    if (at_bot) begin
      stk_tstate = '0; stk_tpc = '0; stk_tnpc = '0; stk_tt = '0; stk_htstate = '0;
    end else begin
      stk_tstate  = tst_m[tl - TLW'(1)];
      stk_tpc     = tpc_m[tl - TLW'(1)];
      stk_tnpc    = tnpc_m[tl - TLW'(1)];
      stk_tt      = tt_m[tl - TLW'(1)];
      stk_htstate = hts_m[tl - TLW'(1)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl <= '0; error_state <= 1'b0; trap_done <= 1'b0; ret_done <= 1'b0;
      nxt_pc <= '0; nxt_npc <= '0; nxt_nnpc <= '0; nxt_ccr <= '0; nxt_asi <= '0;
      nxt_pstate <= '0; nxt_hpstate <= '0; nxt_cwp <= '0; nxt_gl <= '0;
      for (int i = 0; i < MAX_TL; i++) begin
        tst_m[i] <= '0; tpc_m[i] <= '0; tnpc_m[i] <= '0; tt_m[i] <= '0; hts_m[i] <= '0;
      end
    end else begin
      trap_done <= take;
      ret_done  <= back;
      if (trap_req && at_top) error_state <= 1'b1;
      if (take) begin
        tl <= tl + TLW'(1);
        tst_m[tl]  <= tst_new;
        tpc_m[tl]  <= cur_pc;
        tnpc_m[tl] <= cur_npc;
        tt_m[tl]   <= trap_type;
        hts_m[tl]  <= cur_hpstate;
        nxt_ccr     <= cur_ccr;
        nxt_asi     <= cur_asi;
        nxt_pstate  <= ps_new;
        nxt_hpstate <= hps_new;
        nxt_cwp     <= cwp_new;
        nxt_gl      <= gl_new;
        if (spill || fill) begin
          nxt_pc   <= base;
          nxt_npc  <= base + 64'd4;
          nxt_nnpc <= base + 64'd8;
        end else begin
          nxt_pc   <= cur_pc;
          nxt_npc  <= cur_npc;
          nxt_nnpc <= cur_npc + 64'd4;
        end
      end else if (back) begin
        tl <= tl - TLW'(1);
        nxt_gl      <= stk_tstate[42:40];
        nxt_ccr     <= stk_tstate[39:32];
        nxt_asi     <= stk_tstate[31:24];
        nxt_pstate  <= stk_tstate[20:8];
        nxt_cwp     <= stk_tstate[CW-1:0];
        nxt_hpstate <= stk_htstate;
        nxt_pc      <= stk_tpc;
        nxt_npc     <= stk_tnpc;
        nxt_nnpc    <= stk_tnpc + 64'd4;
      end
    end
  end

endmodule

module trap_entry_unit_chk #(
  parameter int MAX_TL = 6,
  parameter int MAX_PGL = 2,
  parameter int TLW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trap_req,
  input logic           done_ret,
  input logic           hyp_mode,
  input logic [TLW-1:0] tl,
  input logic           error_state,
  input logic           trap_done,
  input logic           ret_done,
  input logic [12:0]    nxt_pstate,
  input logic [2:0]     nxt_gl
);

  // R2
  tl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && tl != TLW'(MAX_TL) |=> tl == $past(tl) + TLW'(1) && trap_done);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && tl == TLW'(MAX_TL) |=> tl == TLW'(MAX_TL) && error_state && !trap_done);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_state |=> error_state);

  // R11
  tl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ret && !trap_req && tl != '0 |=> tl == $past(tl) - TLW'(1) && ret_done);

  // R11
  ret_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ret && !trap_req && tl == '0 |=> tl == '0 && !ret_done);

  // R4
  pstate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && tl != TLW'(MAX_TL) |=> nxt_pstate[4] && !nxt_pstate[3] && !nxt_pstate[1]);

  // R6
  gl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !hyp_mode && tl != TLW'(MAX_TL) |=> nxt_gl <= 3'(MAX_PGL));

  // R12
  one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_done && ret_done));

endmodule

bind trap_entry_unit trap_entry_unit_chk #(.MAX_TL(MAX_TL), .MAX_PGL(MAX_PGL), .TLW(TLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .done_ret(done_ret), .hyp_mode(hyp_mode),
  .tl(tl), .error_state(error_state), .trap_done(trap_done), .ret_done(ret_done),
  .nxt_pstate(nxt_pstate), .nxt_gl(nxt_gl)
);

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
  localparam logic [63:0] SPB = 64'h0000_0000_0001_0000;
  localparam logic [63:0] FLB = 64'h0000_0000_0002_0000;

  logic clk = 0, rst_n = 0;
  logic trap_req = 0, hyp_mode = 0, done_ret = 0;
  logic [8:0] trap_type = 0;
  logic [63:0] cur_pc = 0, cur_npc = 0;
  logic [7:0] cur_ccr = 0, cur_asi = 0;
  logic [12:0] cur_pstate = 0;
  logic [11:0] cur_hpstate = 0;
  logic [2:0] cur_cwp = 0, cur_cansave = 0, cur_gl = 0;
  logic [2:0] tl;
  logic error_state, trap_done, ret_done;
  logic [63:0] nxt_pc, nxt_npc, nxt_nnpc, stk_tstate, stk_tpc, stk_tnpc;
  logic [7:0] nxt_ccr, nxt_asi;
  logic [12:0] nxt_pstate;
  logic [11:0] nxt_hpstate, stk_htstate;
  logic [2:0] nxt_cwp, nxt_gl;
  logic [8:0] stk_tt;

  trap_entry_unit uut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [63:0] pc, npc, nnpc, tst, tpc, tnpc;
    logic [7:0] ccr, asi;
    logic [12:0] ps;
    logic [11:0] hps, hts;
    logic [2:0] cwp, gl, tl;
    logic [8:0] tt;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic [2:0] m_tl = 0;
  logic [63:0] m_tst [1:6], m_tpc [1:6], m_tnpc [1:6];
  logic [8:0] m_tt [1:6];
  logic [11:0] m_hts [1:6];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic item_t stk_view(item_t it, logic [2:0] lvl);
    if (lvl == 0) begin
      it.tst = 0; it.tpc = 0; it.tnpc = 0; it.tt = 0; it.hts = 0;
    end else begin
      it.tst = m_tst[lvl]; it.tpc = m_tpc[lvl]; it.tnpc = m_tnpc[lvl];
      it.tt = m_tt[lvl]; it.hts = m_hts[lvl];
    end
    it.tl = lvl;
    return it;
  endfunction

  task automatic do_trap(logic [8:0] tt, logic hyp, logic [63:0] pc, logic [63:0] npc,
                         logic [7:0] ccr, logic [7:0] asi, logic [12:0] ps, logic [11:0] hps,
                         logic [2:0] cwp, logic [2:0] cs, logic [2:0] gl, logic with_ret);
    item_t e;
    int w, lim;
    @(negedge clk);
    trap_type = tt; hyp_mode = hyp; cur_pc = pc; cur_npc = npc; cur_ccr = ccr;
    cur_asi = asi; cur_pstate = ps; cur_hpstate = hps; cur_cwp = cwp;
    cur_cansave = cs; cur_gl = gl; trap_req = 1; done_ret = with_ret;
    if (m_tl < 6) begin
      m_tl++;
      m_tst[m_tl] = 64'(gl) << 40 | 64'(ccr) << 32 | 64'(asi) << 24 | 64'(ps) << 8 | 64'(cwp);
      m_tpc[m_tl] = pc; m_tnpc[m_tl] = npc; m_tt[m_tl] = tt; m_hts[m_tl] = hps;
      e.ccr = ccr; e.asi = asi;
      e.ps = ps; e.ps[4] = 1; e.ps[3] = 0; e.ps[1] = 0;
      e.ps[2] = !hyp; e.ps[9] = hyp ? 1'b0 : ps[8];
      e.hps = hps;
      if (hyp) begin e.hps[5] = 0; e.hps[10] = 0; e.hps[2] = 1; end
      lim = hyp ? 3 : 2;
      e.gl = (int'(gl) + 1 > lim) ? 3'(lim) : gl + 3'd1;
      w = cwp;
      if (tt == 9'h024) w = w + 1;
      else if (tt >= 9'h080 && tt <= 9'h0BF) w = w + cs + 2;
      else if (tt >= 9'h0C0 && tt <= 9'h0FF) w = w + 7;
      e.cwp = 3'(w % 8);
      if (tt >= 9'h080 && tt <= 9'h0BF) begin
        e.pc = SPB; e.npc = SPB + 4; e.nnpc = SPB + 8;
      end else if (tt >= 9'h0C0 && tt <= 9'h0FF) begin
        e.pc = FLB; e.npc = FLB + 4; e.nnpc = FLB + 8;
      end else begin
        e.pc = pc; e.npc = npc; e.nnpc = npc + 4;
      end
      q.push_back(stk_view(e, m_tl));
    end
    @(negedge clk);
    trap_req = 0; done_ret = 0;
  endtask

  task automatic do_ret();
    item_t e;
    logic [63:0] t;
    @(negedge clk);
    done_ret = 1;
    if (m_tl > 0) begin
      t = m_tst[m_tl];
      e.gl = t[42:40]; e.ccr = t[39:32]; e.asi = t[31:24]; e.ps = t[20:8]; e.cwp = t[2:0];
      e.hps = m_hts[m_tl]; e.pc = m_tpc[m_tl]; e.npc = m_tnpc[m_tl]; e.nnpc = m_tnpc[m_tl] + 4;
      m_tl--;
      q.push_back(stk_view(e, m_tl));
    end
    @(negedge clk);
    done_ret = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (trap_done || ret_done)) begin
      if (q.size() == 0) chk("R12 unexpected done", 1, 0);
      else begin
        item_t e;
        e = q.pop_front();
        chk("R2/R11 tl", tl, e.tl);
        chk("R9/R11 pc", nxt_pc, e.pc);
        chk("R9/R11 npc", nxt_npc, e.npc);
        chk("R9/R11 nnpc", nxt_nnpc, e.nnpc);
        chk("R11 ccr", nxt_ccr, e.ccr);
        chk("R11 asi", nxt_asi, e.asi);
        chk("R4 pstate", nxt_pstate, e.ps);
        chk("R5 hpstate", nxt_hpstate, e.hps);
        chk("R7/R8 cwp", nxt_cwp, e.cwp);
        chk("R6 gl", nxt_gl, e.gl);
        chk("R3 tstate", stk_tstate, e.tst);
        chk("R2 tpc", stk_tpc, e.tpc);
        chk("R2 tnpc", stk_tnpc, e.tnpc);
        chk("R2 tt", stk_tt, e.tt);
        chk("R2 htstate", stk_htstate, e.hts);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 tl", tl, 0);
    chk("R1 error_state", error_state, 0);
    chk("R1 trap_done", trap_done, 0);
    chk("R1 ret_done", ret_done, 0);
    chk("R1 nxt_pc", nxt_pc, 0);
    chk("R1 stk_tstate", stk_tstate, 0);
    do_ret();
    chk("R11 idle ret_done", ret_done, 0);
    chk("R11 idle tl", tl, 0);
    // R7 R8: 0x24 from window 7 wraps to 0
    do_trap(9'h024, 0, 64'h100, 64'h104, 8'hA5, 8'h80, 13'h1F0F, 12'hFFF, 3'd7, 3'd1, 3'd0, 0);
    // R9: spill at hypervisor level, sum 10 wraps to 2
    do_trap(9'h080, 1, 64'h200, 64'h204, 8'h3C, 8'h14, 13'h0100, 12'h425, 3'd5, 3'd3, 3'd1, 0);
    // fill from window 0, global level already at the privileged limit
    do_trap(9'h0C0, 0, 64'h300, 64'h304, 8'h01, 8'hFE, 13'h0000, 12'h000, 3'd0, 3'd2, 3'd2, 0);
    // internal error type: window unchanged
    do_trap(9'h029, 0, 64'h400, 64'h404, 8'h77, 8'h55, 13'h1EFF, 12'h0F0, 3'd3, 3'd6, 3'd0, 0);
    // spill top boundary, hypervisor at its limit
    do_trap(9'h0BF, 1, 64'h500, 64'h504, 8'hC3, 8'h33, 13'h0A5A, 12'hFFF, 3'd6, 3'd7, 3'd3, 0);
    // fill top boundary
    do_trap(9'h0FF, 0, 64'h600, 64'h604, 8'h99, 8'h66, 13'h1234, 12'h123, 3'd4, 3'd0, 3'd1, 0);
    // R10: overflow
    do_trap(9'h100, 0, 64'h700, 64'h704, 8'hFF, 8'hFF, 13'h1FFF, 12'hFFF, 3'd1, 3'd1, 3'd1, 0);
    chk("R10 error_state", error_state, 1);
    chk("R10 tl", tl, 6);
    chk("R10 tt kept", stk_tt, 9'h0FF);
    chk("R10 tpc kept", stk_tpc, 64'h600);
    do_ret();
    do_ret();
    // R12: trap wins over return (type 0x07F leaves window and pc alone)
    do_trap(9'h07F, 0, 64'h800, 64'h804, 8'h12, 8'h34, 13'h0100, 12'h000, 3'd2, 3'd5, 3'd1, 1);
    chk("R12 tl", tl, 5);
    for (int i = 0; i < 5; i++) do_ret();
    do_ret();
    chk("R11 tl zero", tl, 0);
    chk("R10 still set", error_state, 1);
    repeat (3) @(negedge clk);
    chk("R2 queue drained", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule